// File: doc/BRIEF.md
# Equal-Exponent Same-Sign Floating-Point Adder

This block adds two binary floating-point words that share both their sign and their biased exponent. The format is chosen by the `WIDTH` parameter: 16 bits (5-bit exponent, 10-bit fraction), 32 bits (8/23) or 64 bits (11/52). The two implicit leading ones of equal-exponent normal operands always add up to two. The sum therefore always moves up by exactly one exponent step. When the fraction sum is even, the result is exact and takes a direct shift-by-one path. When it is odd, the result lies exactly halfway between two representable values and goes to a round-and-pack unit that applies the requested rounding mode.

Subnormal operands are added as raw integers. Infinities pass through. NaNs are propagated with their quiet bit forced on. A request whose exponents or signs differ is not computed: it raises an unsupported indication and returns zero. Operands enter through a valid/ready stream and results leave through a second one, after one register stage. An accepted operand pair produces its result on the output one cycle later. When the output is not taken, that result is held and no new pair is accepted. Back-pressure on the output therefore propagates straight to the input.

Top module: `fadd_eqexp`

## Requirements
- R1: When the shared exponent is all zeros, the result word is operand A plus the zero-extended fraction of operand B, added as unsigned integers, and the flags are 0.
- R2: When the shared exponent is all ones and both fractions are zero, the result is operand A unchanged, and the flags are 0.
- R3: When the shared exponent is all ones and either fraction is nonzero, the result is operand A if its fraction is nonzero, otherwise operand B, with the top fraction bit set. Flag bit 2 (invalid) is set if either operand is signaling, meaning an all-ones exponent, a nonzero fraction and a clear top fraction bit.
- R4: For a normal exponent below the largest normal value, if the fraction sum is even, the result has exponent plus one and fraction equal to half the fraction sum, and the flags are 0.
- R5: For a normal exponent with an odd fraction sum, the halfway result is rounded by the `in_rm` code and flag bit 0 (inexact) is set. The codes are: 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest with ties away from zero, and 5 to 7 treated as toward zero.
- R6: If the rounded result exponent reaches all ones (always the case for the largest normal input exponent), the result is infinity for codes 0 and 4, for code 3 with positive sign and for code 2 with negative sign. Otherwise it is the largest finite value of that sign. Flag bits 1 (overflow) and 0 (inexact) are set.
- R7: The sign bit of every supported result equals the sign bit of operand A.
- R8: If the exponents or the sign bits of A and B differ, `out_unsup` is 1, the result is 0 and the flags are 0. For supported requests `out_unsup` is 0.
- R9: `in_ready` is high whenever the output register is empty or is being taken. A pair accepted on a clock edge appears with `out_valid` high after that edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_sum`, `out_flags` and `out_unsup` hold their values and `out_valid` stays high.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_a | input | WIDTH | Operand A |
| in_b | input | WIDTH | Operand B |
| in_rm | input | 3 | Rounding mode code |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | WIDTH | Result word |
| out_flags | output | 3 | {invalid, overflow, inexact} |
| out_unsup | output | 1 | Request had unequal exponents or signs |

## Verification
The overflow boundary is the hardest situation to reach from the ports. It needs the largest normal exponent, which always overflows even on the exact path, or a halfway sum for which each rounding mode and sign picks a different side between infinity and the largest finite value. Signaling and quiet NaN fractions in either operand fall in the same class. The bench sweeps every exponent of the 16-bit format, both signs, all mode codes and a grid of fraction patterns. The grid includes zero, single low bits, the quiet bit alone, alternating bits and all ones. This makes each of these boundaries occur many times. A separate sequence holds `out_ready` low to exercise the stall.

// File: rtl/fadd_eqexp_pkg.sv
package fadd_eqexp_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_TO_ZERO   = 3'd1,
    RM_TO_NEG    = 3'd2,
    RM_TO_POS    = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic inexact;
  } fflags_t;

  function automatic int exp_bits(input int width);
    if (width == 16) return 5;
    else if (width == 64) return 11;
    else return 8;
  endfunction

endpackage

// File: rtl/fadd_eqexp_decode.sv
module fadd_eqexp_decode #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] word,
  output logic           is_nan,
  output logic           is_snan,
  output logic           frac_zero
);
  logic [EW-1:0] expf;
  logic [FW-1:0] frac;

  assign expf      = word[EW+FW-1:FW];
  assign frac      = word[FW-1:0];
  assign frac_zero = (frac == '0);
  assign is_nan    = (&expf) && !frac_zero;
  assign is_snan   = is_nan && !frac[FW-1];
endmodule

// File: rtl/fadd_eqexp_nanpick.sv
module fadd_eqexp_nanpick #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] op_a,
  input  logic [EW+FW:0] op_b,
  input  logic           a_nan,
  input  logic           a_snan,
  input  logic           b_snan,
  output logic [EW+FW:0] word,
  output logic           invalid
);
  localparam logic [EW+FW:0] QUIET_BIT = (EW+FW+1)'(1) << (FW - 1);

  assign word    = (a_nan ? op_a : op_b) | QUIET_BIT;
  assign invalid = a_snan || b_snan;
endmodule

// File: rtl/fadd_eqexp_round.sv
module fadd_eqexp_round
  import fadd_eqexp_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic          sign,
  input  logic [EW-1:0] expf,
  input  logic [FW:0]   fsum,
  input  logic [2:0]    rm,
  output logic [EW+FW-1:0] mag,
  output logic          ovf,
  output logic          nx
);
  localparam int MW = EW + 1 + FW;
  localparam logic [EW:0] EXP_TOP = {1'b0, {EW{1'b1}}};
  localparam logic [EW+FW-1:0] INF_MAG = {{EW{1'b1}}, {FW{1'b0}}};
  localparam logic [EW+FW-1:0] MAX_MAG = {{(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};

  logic [FW:0]   mant;
  logic          half;
  logic          bump;
  logic          to_inf;
  logic [MW-1:0] grown;
  logic [MW-1:0] rounded;

  assign mant = {1'b1, fsum[FW:1]};
  assign half = fsum[0];

  always_comb begin
    bump   = 1'b0;
    to_inf = 1'b0;
    case (rmode_e'(rm))
      RM_NEAR_EVEN: begin bump = mant[0]; to_inf = 1'b1;  end
      RM_NEAR_AWAY: begin bump = 1'b1;    to_inf = 1'b1;  end
      RM_TO_POS:    begin bump = !sign;   to_inf = !sign; end
      RM_TO_NEG:    begin bump = sign;    to_inf = sign;  end
      default:      begin bump = 1'b0;    to_inf = 1'b0;  end
    endcase
  end

  assign grown   = {({1'b0, expf} + {{EW{1'b0}}, 1'b1}), mant[FW-1:0]};
  assign rounded = grown + {{(MW-1){1'b0}}, bump & half};
  assign ovf     = (rounded[MW-1:FW] >= EXP_TOP);
  assign nx      = half || ovf;
  assign mag     = ovf ? (to_inf ? INF_MAG : MAX_MAG) : rounded[EW+FW-1:0];
endmodule

// File: rtl/fadd_eqexp.sv
module fadd_eqexp
  import fadd_eqexp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [2:0]       in_rm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum,
  output logic [2:0]       out_flags,
  output logic             out_unsup
);
  localparam int EW = exp_bits(WIDTH);
  localparam int FW = WIDTH - 1 - EW;
  localparam logic [EW-1:0] EXP_MAXN = {{(EW-1){1'b1}}, 1'b0};

  logic [WIDTH-1:0] ops [2];
  logic [1:0] nan_v, snan_v, fz_v;

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    fadd_eqexp_decode #(.EW(EW), .FW(FW)) u_dec (
      .word      (ops[g]),
      .is_nan    (nan_v[g]),
      .is_snan   (snan_v[g]),
      .frac_zero (fz_v[g])
    );
  end

  logic          sa;
  logic [EW-1:0] ea;
  logic [FW:0]   fsum;
  logic          same_ok;

  assign sa      = in_a[WIDTH-1];
  assign ea      = in_a[WIDTH-2:FW];
  assign fsum    = {1'b0, in_a[FW-1:0]} + {1'b0, in_b[FW-1:0]};
  assign same_ok = (ea == in_b[WIDTH-2:FW]) && (sa == in_b[WIDTH-1]);

  logic [WIDTH-1:0] nan_word;
  logic             nan_inv;

  fadd_eqexp_nanpick #(.EW(EW), .FW(FW)) u_nan (
    .op_a    (in_a),
    .op_b    (in_b),
    .a_nan   (nan_v[0]),
    .a_snan  (snan_v[0]),
    .b_snan  (snan_v[1]),
    .word    (nan_word),
    .invalid (nan_inv)
  );

  logic [WIDTH-2:0] rnd_mag;
  logic             rnd_ovf, rnd_nx;

  fadd_eqexp_round #(.EW(EW), .FW(FW)) u_rnd (
    .sign (sa),
    .expf (ea),
    .fsum (fsum),
    .rm   (in_rm),
    .mag  (rnd_mag),
    .ovf  (rnd_ovf),
    .nx   (rnd_nx)
  );

  logic [WIDTH-1:0] nxt_sum;
  fflags_t          nxt_flags;
  logic             nxt_unsup;

  always_comb begin
    nxt_sum   = '0;
    nxt_flags = '0;
    nxt_unsup = 1'b0;
    if (!same_ok) begin
      nxt_unsup = 1'b1;
    end else if (ea == '0) begin
      nxt_sum = in_a + {{(EW+1){1'b0}}, in_b[FW-1:0]};
    end else if ((&ea) && fz_v[0] && fz_v[1]) begin
      nxt_sum = in_a;
    end else if (&ea) begin
      nxt_sum           = nan_word;
      nxt_flags.invalid = nan_inv;
    end else if (!fsum[0] && (ea != EXP_MAXN)) begin
      nxt_sum = {sa, ea + EW'(1), fsum[FW:1]};
    end else begin
      nxt_sum            = {sa, rnd_mag};
      nxt_flags.overflow = rnd_ovf;
      nxt_flags.inexact  = rnd_nx;
    end
  end

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_flags <= '0;
      out_unsup <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_sum   <= nxt_sum;
        out_flags <= nxt_flags;
        out_unsup <= nxt_unsup;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fadd_eqexp_checks.sv
module fadd_eqexp_checks
  import fadd_eqexp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_a,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_sum,
  input logic [2:0]       out_flags,
  input logic             out_unsup
);
  localparam int EW = exp_bits(WIDTH);
  localparam int FW = WIDTH - 1 - EW;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_flags) && $stable(out_unsup))); // R10

  AST_NO_TAKE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_VALID_FROM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R9

  AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unsup) |-> (out_sum == '0 && out_flags == 3'b000)); // R8

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_sum[WIDTH-2:FW]) && (out_sum[FW-1:0] != '0)) |-> out_sum[FW-1]); // R3

  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> out_flags[0]); // R6

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready) && !out_unsup) |-> (out_sum[WIDTH-1] == $past(in_a[WIDTH-1]))); // R7
endmodule

bind fadd_eqexp fadd_eqexp_checks #(.WIDTH(WIDTH)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .out_flags (out_flags),
  .out_unsup (out_unsup)
);

// File: tb/fadd_eqexp_test.sv
module fadd_eqexp_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [2:0]   in_rm = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_sum;
  logic [2:0]   out_flags;
  logic         out_unsup;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fadd_eqexp #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_rm(in_rm), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_flags(out_flags),
    .out_unsup(out_unsup)
  );

  function automatic logic [9:0] pat(input int i);
    case (i)
      0: return 10'h000;  1: return 10'h001;  2: return 10'h002;
      3: return 10'h003;  4: return 10'h155;  5: return 10'h2AA;
      6: return 10'h1FF;  7: return 10'h200;  8: return 10'h201;
      9: return 10'h3FE;  10: return 10'h3FF; default: return 10'h0F0;
    endcase
  endfunction

  // returns {unsup, flags[2:0], sum[15:0]}; cat names the requirement
  function automatic logic [19:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [2:0] rm, output string cat);
    logic s;
    int ea, eb, fa, fb, tot, q, r, e, up, toinf;
    logic snan;
    s  = a[15];
    ea = int'(a[14:10]); eb = int'(b[14:10]);
    fa = int'(a[9:0]);   fb = int'(b[9:0]);
    if (ea != eb || a[15] != b[15]) begin
      cat = "R8"; return {1'b1, 3'b000, 16'h0000};
    end
    if (ea == 0) begin
      cat = "R1"; return {1'b0, 3'b000, a + 16'(fb)};
    end
    if (ea == 31) begin
      if (fa == 0 && fb == 0) begin cat = "R2"; return {1'b0, 3'b000, a}; end
      snan = (fa != 0 && a[9] == 1'b0) || (fb != 0 && b[9] == 1'b0);
      cat = "R3";
      return {1'b0, snan, 2'b00, ((fa != 0) ? a : b) | 16'h0200};
    end
    tot = 2048 + fa + fb;
    q = tot / 2; r = tot % 2; e = ea + 1;
    case (rm)
      3'd0: up = q % 2;
      3'd4: up = 1;
      3'd3: up = s ? 0 : 1;
      3'd2: up = s ? 1 : 0;
      default: up = 0;
    endcase
    if (r == 0) up = 0;
    q = q + up;
    if (q == 2048) begin q = 1024; e = e + 1; end
    if (e >= 31) begin
      toinf = (rm == 3'd0 || rm == 3'd4 || (rm == 3'd3 && !s) || (rm == 3'd2 && s)) ? 1 : 0;
      cat = "R6";
      return {1'b0, 3'b011, toinf != 0 ? {s, 5'h1F, 10'h000} : {s, 5'h1E, 10'h3FF}};
    end
    cat = (r != 0) ? "R5" : "R4";
    return {1'b0, 2'b00, r[0], s, e[4:0], q[9:0]};
  endfunction

  task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h rm=%0d actual=%h expected=%h", req, in_a, in_b, in_rm, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic [2:0] rm);
    string cat;
    logic [19:0] exp;
    in_a = a; in_b = b; in_rm = rm; in_valid = 1'b1;
    exp = model(a, b, rm, cat);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", {19'b0, out_valid}, 20'd1);
    check(cat, {out_unsup, out_flags, out_sum}, exp);
    if (!exp[19]) check("R7", {19'b0, out_sum[15]}, {19'b0, a[15]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [19:0] first;
    string c;
    repeat (3) @(negedge clk);
    check("R11", {18'b0, out_valid, in_ready}, 20'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {18'b0, out_valid, in_ready}, 20'b01);

    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 32; e++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++)
            for (int rm = 0; rm < 6; rm++)
              send({s[0], e[4:0], pat(i)}, {s[0], e[4:0], pat(j)}, rm[2:0]);
    send({1'b0, 5'd30, 10'h155}, {1'b0, 5'd30, 10'h0F0}, 3'd7);
    send({1'b1, 5'd30, 10'h001}, {1'b1, 5'd30, 10'h002}, 3'd6);

    for (int k = 0; k < 64; k++) begin
      logic [15:0] a;
      a = 16'(k * 1031 + 7);
      send(a, a ^ (16'h0400 << (k % 5)), 3'(k % 5));
      send(a, a ^ 16'h8000, 3'(k % 5));
    end

    // stall: output held, input blocked, then second result follows
    @(negedge clk);
    out_ready = 1'b0;
    in_a = {1'b0, 5'd10, 10'h003}; in_b = {1'b0, 5'd10, 10'h000}; in_rm = 3'd0;
    in_valid = 1'b1;
    first = model(in_a, in_b, in_rm, c);
    @(negedge clk);
    check("R9", {19'b0, in_ready}, 20'd0);
    in_a = {1'b1, 5'd3, 10'h002}; in_b = {1'b1, 5'd3, 10'h004};
    repeat (3) @(negedge clk);
    check("R10", {out_unsup, out_flags, out_sum}, first);
    check("R10", {19'b0, out_valid}, 20'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", {out_unsup, out_flags, out_sum}, {4'b0000, 1'b1, 5'd4, 10'h003});
    @(negedge clk);
    check("R9", {19'b0, out_valid}, 20'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule